// File: doc/BRIEF.md
# Paged One-Time-Programmable Array Controller

This block gives a host processor register access to an array of 512 pages of 128 bits. The array is held in ordinary on-chip storage, and every page can be read and rewritten any number of times. The host first loads four 32-bit data words and a 16-bit byte-enable mask. It then writes the control register with a page number and a command. A write command copies the data words into the page. A read command copies the page into the data words. In both directions only the bytes selected by the mask move. Every control write raises a done flag, and the host clears that flag by writing a one to it.

The bus side is a plain request/response port with no back-pressure. A request is accepted in the cycle it is presented. Exactly one cycle later the block returns a response strobe, an error flag and the read data. The request also carries its access size: 16 or 32 bits. Each register accepts only one size. An access of the wrong size, or to an unmapped offset, ends with an error and changes nothing.

Top module: `otp_page_ctrl`

## Requirements
- R1: After reset, control, status, the four data words and `done_o` are zero. The byte-enable mask reads 0xFFFF and the timing register reads 0x00001485.
- R2: Only these offsets are mapped: control 0x00, byte-enable 0x04, status 0x08, timing 0x0C, and data words 0..3 at 0x80, 0x84, 0x88 and 0x8C. Any other offset returns an error, reads as zero, and changes no register.
- R3: Control, byte-enable and status accept only 16-bit accesses (`bus_size32`=0). Timing and the data words accept only 32-bit accesses (`bus_size32`=1). An access of the wrong size returns an error and changes nothing.
- R4: A control write stores the written value ANDed with 0x39FF.
- R5: Bits [8:0] of a control write select the page. When bit 15 of the written value is 1, the data words are copied into that page. Data word 0 fills page bytes 0..3 (byte 0 in bits 7:0), and data word 3 fills page bytes 12..15.
- R6: When bit 13 of the written control value is 1, the selected page is copied into the data words, using the same byte placement as R5.
- R7: In both transfer directions, page byte i moves only when byte-enable bit i is 1. Bytes whose enable bit is 0 keep their old value at the destination.
- R8: When bits 15 and 13 are both set, the page write completes before the page read. The read therefore returns the freshly written bytes.
- R9: Every accepted control write sets status bit 0, with or without a command. `done_o` follows that bit. Writing a 1 to any status bit clears it, and writing a 0 leaves it unchanged.
- R10: The byte-enable mask is fully writable. Timing and the data words read back exactly what was written.
- R11: Every request is answered by `rsp_valid` exactly one cycle later. `rsp_err` is set only for rejected accesses. Reads of 16-bit registers return the value zero-extended to 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_req | input | 1 | Request strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_size32 | input | 1 | Access size: 1 = 32 bits, 0 = 16 bits |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data (low 16 bits for 16-bit registers) |
| rsp_valid | output | 1 | Response strobe, one cycle after a request |
| rsp_err | output | 1 | Access rejected (bad offset or size) |
| rsp_rdata | output | 32 | Read data, zero for writes and rejected accesses |
| done_o | output | 1 | High while the done flag in status is set |

## Verification
The properties assume that `bus_req` and its qualifiers are never unknown while out of reset. They also assume that the byte-enable mask changes only through an accepted 16-bit write at offset 0x04. The response and done-flag checks take each request to be a single strobe, so the properties never have to sort out the response to one access from the next. The stimulus raises `bus_req` for one cycle and always leaves at least one idle cycle after it. It drives every input on the falling clock edge, so nothing changes while the design samples.

// File: rtl/otp_pkg.sv
package otp_pkg;

  localparam int unsigned PG_BYTES = 16;
  localparam int unsigned PG_BITS  = PG_BYTES * 8;
  localparam int unsigned DWORDS   = PG_BITS / 32;

  localparam logic [7:0] OFS_CTL  = 8'h00;
  localparam logic [7:0] OFS_BEN  = 8'h04;
  localparam logic [7:0] OFS_STS  = 8'h08;
  localparam logic [7:0] OFS_TIM  = 8'h0C;
  localparam logic [3:0] OFS_DATA_HI = 4'h8;

  localparam logic [15:0] CTL_KEEP   = 16'h39FF;
  localparam int unsigned CTL_RD_BIT = 13;
  localparam int unsigned CTL_WR_BIT = 15;

  localparam logic [15:0] BEN_INIT = 16'hFFFF;
  localparam logic [31:0] TIM_INIT = 32'h0000_1485;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CTL,
    SEL_BEN,
    SEL_STS,
    SEL_TIM,
    SEL_DAT
  } reg_sel_e;

  // byte i of the result comes from new_v when ben[i] is set
  function automatic logic [PG_BITS-1:0] byte_merge(
    input logic [PG_BITS-1:0]  old_v,
    input logic [PG_BITS-1:0]  new_v,
    input logic [PG_BYTES-1:0] ben
  );
    logic [PG_BITS-1:0] r;
    for (int i = 0; i < PG_BYTES; i++)
      r[8*i +: 8] = ben[i] ? new_v[8*i +: 8] : old_v[8*i +: 8];
    return r;
  endfunction

endpackage

// File: rtl/otp_regdec.sv
module otp_regdec
  import otp_pkg::*;
(
  input  logic [7:0] addr,
  input  logic       size32,
  output reg_sel_e   sel,
  output logic [1:0] widx,
  output logic       bad
);

  logic wide;

  always_comb begin
    sel  = SEL_NONE;
    widx = addr[3:2];
    unique case (addr)
      OFS_CTL: sel = SEL_CTL;
      OFS_BEN: sel = SEL_BEN;
      OFS_STS: sel = SEL_STS;
      OFS_TIM: sel = SEL_TIM;
      default: begin
        if (addr[7:4] == OFS_DATA_HI && addr[1:0] == 2'b00)
          sel = SEL_DAT;
      end
    endcase
  end

  assign wide = (sel == SEL_TIM) || (sel == SEL_DAT);

  always_comb begin
    if (sel == SEL_NONE)
      bad = 1'b1;
    else
      bad = (wide != size32);
  end

endmodule

// File: rtl/otp_page_array.sv
module otp_page_array
  import otp_pkg::*;
#(
  parameter int unsigned PAGES = 512,
  localparam int unsigned PAW  = $clog2(PAGES)
) (
  input  logic                clk,
  input  logic                wr_en,
  input  logic [PAW-1:0]      wr_page,
  input  logic [PG_BITS-1:0]  wr_data,
  input  logic [PG_BYTES-1:0] wr_ben,
  input  logic [PAW-1:0]      rd_page,
  output logic [PG_BITS-1:0]  rd_data
);

  logic [PG_BITS-1:0] mem [PAGES];
  logic [PG_BITS-1:0] merged;

  assign merged = byte_merge(mem[wr_page], wr_data, wr_ben);

  always_ff @(posedge clk) begin
    if (wr_en)
      mem[wr_page] <= merged;
  end

  // a same-cycle write to the read page is seen by the read
  assign rd_data = (wr_en && (wr_page == rd_page)) ? merged : mem[rd_page];

endmodule

// File: rtl/otp_page_ctrl.sv
module otp_page_ctrl
  import otp_pkg::*;
#(
  parameter int unsigned PAGES = 512,
  localparam int unsigned PAW  = $clog2(PAGES)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_req,
  input  logic        bus_we,
  input  logic        bus_size32,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic        rsp_valid,
  output logic        rsp_err,
  output logic [31:0] rsp_rdata,
  output logic        done_o
);

  reg_sel_e           sel;
  logic [1:0]         widx;
  logic               bad;
  logic               wr_ok;
  logic               ctl_go;
  logic               cmd_wr;
  logic               cmd_rd;
  logic [PAW-1:0]     page;
  logic [PG_BITS-1:0] pg_rd;
  logic [31:0]        rmux;

  logic [15:0]             ctl_q;
  logic [PG_BYTES-1:0]     ben_q;
  logic [15:0]             sts_q;
  logic [31:0]             tim_q;
  logic [DWORDS-1:0][31:0] data_q;

  otp_regdec u_dec (
    .addr   (bus_addr),
    .size32 (bus_size32),
    .sel    (sel),
    .widx   (widx),
    .bad    (bad)
  );

  assign wr_ok  = bus_req && bus_we && !bad;
  assign ctl_go = wr_ok && (sel == SEL_CTL);
  assign cmd_wr = ctl_go && bus_wdata[CTL_WR_BIT];
  assign cmd_rd = ctl_go && bus_wdata[CTL_RD_BIT];
  assign page   = bus_wdata[PAW-1:0];

  otp_page_array #(.PAGES(PAGES)) u_arr (
    .clk     (clk),
    .wr_en   (cmd_wr),
    .wr_page (page),
    .wr_data (data_q),
    .wr_ben  (ben_q),
    .rd_page (page),
    .rd_data (pg_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      ben_q  <= BEN_INIT;
      sts_q  <= '0;
      tim_q  <= TIM_INIT;
      data_q <= '0;
    end else begin
      if (wr_ok) begin
        unique case (sel)
          SEL_CTL: ctl_q        <= bus_wdata[15:0] & CTL_KEEP;
          SEL_BEN: ben_q        <= bus_wdata[15:0];
          SEL_TIM: tim_q        <= bus_wdata;
          SEL_DAT: data_q[widx] <= bus_wdata;
          default: ;
        endcase
      end
      if (cmd_rd)
        data_q <= byte_merge(data_q, pg_rd, ben_q);
      if (ctl_go)
        sts_q[0] <= 1'b1;
      else if (wr_ok && sel == SEL_STS)
        sts_q <= sts_q & ~bus_wdata[15:0];
    end
  end

  always_comb begin
    unique case (sel)
      SEL_CTL: rmux = {16'h0, ctl_q};
      SEL_BEN: rmux = {16'h0, ben_q};
      SEL_STS: rmux = {16'h0, sts_q};
      SEL_TIM: rmux = tim_q;
      SEL_DAT: rmux = data_q[widx];
      default: rmux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= bus_req;
      rsp_err   <= bus_req && bad;
      rsp_rdata <= (bus_req && !bus_we && !bad) ? rmux : 32'h0;
    end
  end

  assign done_o = sts_q[0];

endmodule

// File: rtl/otp_page_ctrl_chk.sv
module otp_page_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_req,
  input logic        bus_we,
  input logic        bus_size32,
  input logic [7:0]  bus_addr,
  input logic        clr0,
  input logic        rsp_valid,
  input logic        rsp_err,
  input logic        done_o,
  input logic [15:0] ben_q
);

  logic mapped;
  logic narrow;

  assign narrow = (bus_addr == 8'h00) || (bus_addr == 8'h04) || (bus_addr == 8'h08);
  assign mapped = narrow || (bus_addr == 8'h0C) || (bus_addr == 8'h80) ||
                  (bus_addr == 8'h84) || (bus_addr == 8'h88) || (bus_addr == 8'h8C);

  p_rsp_follows_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |=> rsp_valid);

  p_no_rsp_when_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req |=> !rsp_valid);

  p_unmapped_err_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !mapped) |=> rsp_err);

  p_wrong_size_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && narrow && bus_size32) |=> rsp_err);

  p_ctl_sets_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && !bus_size32 && bus_addr == 8'h00) |=> done_o);

  p_done_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !(bus_req && bus_we && !bus_size32 && bus_addr == 8'h08 && clr0))
    |=> done_o);

  p_ben_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_req && bus_we && !bus_size32 && bus_addr == 8'h04) |=> $stable(ben_q));

endmodule

bind otp_page_ctrl otp_page_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_req    (bus_req),
  .bus_we     (bus_we),
  .bus_size32 (bus_size32),
  .bus_addr   (bus_addr),
  .clr0       (bus_wdata[0]),
  .rsp_valid  (rsp_valid),
  .rsp_err    (rsp_err),
  .done_o     (done_o),
  .ben_q      (ben_q)
);

// File: tb/test_otp_page_ctrl.sv
module test_otp_page_ctrl;

  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0;
  logic        bus_we = 1'b0;
  logic        bus_size32 = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        rsp_valid;
  logic        rsp_err;
  logic [31:0] rsp_rdata;
  logic        done_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  otp_page_ctrl i_otp_page_ctrl (
    .clk, .rst_n, .bus_req, .bus_we, .bus_size32, .bus_addr, .bus_wdata,
    .rsp_valid, .rsp_err, .rsp_rdata, .done_o
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic acc(input logic we, input logic s32, input logic [7:0] a,
                     input logic [31:0] wd, output logic [31:0] rd, output logic er);
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_size32 = s32; bus_addr = a; bus_wdata = wd;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
    rd = rsp_rdata; er = rsp_err;
    check("R11 rsp_valid", {31'h0, rsp_valid}, 32'h1);
  endtask

  task automatic wr(input logic s32, input logic [7:0] a, input logic [31:0] v);
    logic [31:0] rd; logic er;
    acc(1'b1, s32, a, v, rd, er);
    check("R11 no error on good write", {31'h0, er}, 32'h0);
  endtask

  task automatic rd_chk(input string req, input logic s32, input logic [7:0] a,
                        input logic [31:0] exp);
    logic [31:0] rd; logic er;
    acc(1'b0, s32, a, 32'h0, rd, er);
    check(req, {31'h0, er}, 32'h0);
    check(req, rd, exp);
  endtask

  task automatic bad_acc(input string req, input logic we, input logic s32,
                         input logic [7:0] a, input logic [31:0] wd);
    logic [31:0] rd; logic er;
    acc(we, s32, a, wd, rd, er);
    check(req, {31'h0, er}, 32'h1);
    check(req, rd, 32'h0);
  endtask

  task automatic set_data(input logic [31:0] w0, input logic [31:0] w1,
                          input logic [31:0] w2, input logic [31:0] w3);
    wr(1'b1, 8'h80, w0); wr(1'b1, 8'h84, w1); wr(1'b1, 8'h88, w2); wr(1'b1, 8'h8C, w3);
  endtask

  task automatic chk_data(input string req, input logic [31:0] w0, input logic [31:0] w1,
                          input logic [31:0] w2, input logic [31:0] w3);
    rd_chk(req, 1'b1, 8'h80, w0); rd_chk(req, 1'b1, 8'h84, w1);
    rd_chk(req, 1'b1, 8'h88, w2); rd_chk(req, 1'b1, 8'h8C, w3);
  endtask

  task automatic t_reset;
    check("R1 done_o", {31'h0, done_o}, 32'h0);
    rd_chk("R1 ctl", 1'b0, 8'h00, 32'h0);
    rd_chk("R1 R11 ben zero-extended", 1'b0, 8'h04, 32'h0000FFFF);
    rd_chk("R1 sts", 1'b0, 8'h08, 32'h0);
    rd_chk("R1 timing", 1'b1, 8'h0C, 32'h00001485);
    chk_data("R1 data", 32'h0, 32'h0, 32'h0, 32'h0);
  endtask

  task automatic t_regs_rw;
    wr(1'b0, 8'h04, 32'hABCD1234);
    rd_chk("R10 ben", 1'b0, 8'h04, 32'h00001234);
    wr(1'b0, 8'h04, 32'h0000FFFF);
    wr(1'b1, 8'h0C, 32'hDEADBEEF);
    rd_chk("R10 timing", 1'b1, 8'h0C, 32'hDEADBEEF);
    set_data(32'h11111111, 32'h22222222, 32'h33333333, 32'h44444444);
    chk_data("R10 data", 32'h11111111, 32'h22222222, 32'h33333333, 32'h44444444);
  endtask

  task automatic t_size;
    bad_acc("R3 ctl 32-bit read", 1'b0, 1'b1, 8'h00, 32'h0);
    bad_acc("R3 ben 32-bit write", 1'b1, 1'b1, 8'h04, 32'h00000001);
    rd_chk("R3 ben unchanged", 1'b0, 8'h04, 32'h0000FFFF);
    bad_acc("R3 timing 16-bit write", 1'b1, 1'b0, 8'h0C, 32'h00000000);
    rd_chk("R3 timing unchanged", 1'b1, 8'h0C, 32'hDEADBEEF);
    bad_acc("R3 data 16-bit write", 1'b1, 1'b0, 8'h80, 32'h0);
    rd_chk("R3 data unchanged", 1'b1, 8'h80, 32'h11111111);
    bad_acc("R3 ctl 32-bit write", 1'b1, 1'b1, 8'h00, 32'h00000005);
    check("R3 rejected ctl write leaves done clear", {31'h0, done_o}, 32'h0);
  endtask

  task automatic t_decode;
    bad_acc("R2 offset 0x10", 1'b1, 1'b1, 8'h10, 32'h0);
    bad_acc("R2 offset 0x90 read", 1'b0, 1'b1, 8'h90, 32'h0);
    bad_acc("R2 offset 0x82", 1'b1, 1'b1, 8'h82, 32'h0);
    bad_acc("R2 offset 0x40 16-bit", 1'b1, 1'b0, 8'h40, 32'hFFFF);
    chk_data("R2 data unchanged", 32'h11111111, 32'h22222222, 32'h33333333, 32'h44444444);
    rd_chk("R2 timing unchanged", 1'b1, 8'h0C, 32'hDEADBEEF);
  endtask

  task automatic t_done;
    wr(1'b0, 8'h00, 32'h00000005);
    check("R9 done after plain ctl write", {31'h0, done_o}, 32'h1);
    rd_chk("R9 sts bit0", 1'b0, 8'h08, 32'h1);
    wr(1'b0, 8'h08, 32'h0000FFFE);
    check("R9 writing 0 keeps done", {31'h0, done_o}, 32'h1);
    wr(1'b0, 8'h08, 32'h00000001);
    check("R9 W1C clears done", {31'h0, done_o}, 32'h0);
    rd_chk("R9 sts cleared", 1'b0, 8'h08, 32'h0);
  endtask

  task automatic t_ctl_mask;
    wr(1'b0, 8'h00, 32'h0000FFFF);
    rd_chk("R4 ctl masked", 1'b0, 8'h00, 32'h000039FF);
    wr(1'b0, 8'h00, 32'h0000C600);
    rd_chk("R4 ctl masked 2", 1'b0, 8'h00, 32'h00000000);
    wr(1'b0, 8'h08, 32'h1);
  endtask

  task automatic t_wr_rd;
    set_data(32'hA0A0A0A0, 32'hA1A1A1A1, 32'hA2A2A2A2, 32'hA3A3A3A3);
    wr(1'b0, 8'h00, 32'h00008005);
    set_data(32'hB0B0B0B0, 32'hB1B1B1B1, 32'hB2B2B2B2, 32'hB3B3B3B3);
    wr(1'b0, 8'h00, 32'h00008106);
    set_data(32'h0, 32'h0, 32'h0, 32'h0);
    wr(1'b0, 8'h00, 32'h00002005);
    chk_data("R5 R6 page 5", 32'hA0A0A0A0, 32'hA1A1A1A1, 32'hA2A2A2A2, 32'hA3A3A3A3);
    wr(1'b0, 8'h00, 32'h00002106);
    chk_data("R5 R6 page 0x106", 32'hB0B0B0B0, 32'hB1B1B1B1, 32'hB2B2B2B2, 32'hB3B3B3B3);
  endtask

  task automatic t_ben;
    set_data(32'hE0E0E0E0, 32'hE1E2E3E4, 32'hE2E2E2E2, 32'hE3E3E3E3);
    wr(1'b0, 8'h04, 32'h000000F0);
    wr(1'b0, 8'h00, 32'h00008005);
    wr(1'b0, 8'h04, 32'h0000FFFF);
    set_data(32'h0, 32'h0, 32'h0, 32'h0);
    wr(1'b0, 8'h00, 32'h00002005);
    chk_data("R7 masked page write", 32'hA0A0A0A0, 32'hE1E2E3E4, 32'hA2A2A2A2, 32'hA3A3A3A3);
    set_data(32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF);
    wr(1'b0, 8'h04, 32'h00008001);
    wr(1'b0, 8'h00, 32'h00002005);
    chk_data("R7 masked page read", 32'hFFFFFFA0, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hA3FFFFFF);
    wr(1'b0, 8'h04, 32'h0000FFFF);
  endtask

  task automatic t_both;
    set_data(32'hC0C0C0C0, 32'hC1C1C1C1, 32'hC2C2C2C2, 32'hC3C3C3C3);
    wr(1'b0, 8'h00, 32'h0000A007);
    set_data(32'hD0D0D0D0, 32'hD1D1D1D1, 32'hD2D2D2D2, 32'hD3D3D3D3);
    wr(1'b0, 8'h04, 32'h00000F00);
    wr(1'b0, 8'h00, 32'h0000A007);
    chk_data("R8 write before read keeps data", 32'hD0D0D0D0, 32'hD1D1D1D1,
             32'hD2D2D2D2, 32'hD3D3D3D3);
    wr(1'b0, 8'h04, 32'h0000FFFF);
    wr(1'b0, 8'h00, 32'h00002007);
    chk_data("R8 page after combined op", 32'hC0C0C0C0, 32'hC1C1C1C1,
             32'hD2D2D2D2, 32'hC3C3C3C3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs_rw();
    t_size();
    t_decode();
    t_done();
    t_ctl_mask();
    t_wr_rd();
    t_ben();
    t_both();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule